// File: doc/BRIEF.md
# Serial Command Register Port

This block is the slave end of a four-wire serial control port (active-low chip select, serial clock, data in, data out) in front of a small bank of per-channel registers. Every transaction opens with an 8-bit header: a direction flag, a 5-bit register address sent least significant bit first, one bit that has to be zero, and one bit that is ignored. A write then sends an 8-bit data word into the addressed control register. A read sends the addressed register's 7-bit word back, least significant bit first.

Each channel owns one control register at an even address. Its bits drive six configuration outputs: FIFO depth select, clock edge select, bandwidth select, attenuator bypass, E3/DS3 select and STS-1 select. Each channel also owns a read-only status register at the next odd address, which reports that channel's loss-of-lock input. The block runs on a system clock at least eight times faster than the serial clock. It brings the serial pins through two-flop synchronisers and acts on the serial clock edges that it detects.

Top module: `sctl_port`

## Requirements
- R1: After a synchronous reset, every control output is 0 and `sdo_oe` is 0.
- R2: Header bits are taken on rising serial clock edges in this order: bit 1 is the direction (1 = read, 0 = write), bits 2 to 6 are address bits A0 to A4, bit 7 is A5, and bit 8 is ignored. During a write, and during the header of any frame, `sdo_oe` stays 0.
- R3: In a write, data bits D0 to D7 are taken on rising edges 9 to 16. After the 16th edge, the word is committed to the control register of channel c at address 8*c+6 (c < NCH). The bit layout is: D0 fifo_sel, D1 clk_edge_sel, D2 bw_sel, D3 ja_bypass, D4 e3_sel, D6 sts1_sel. D5 and D7 are discarded.
- R4: In a read, `sdo_oe` rises on the falling edge that follows the 8th rising edge. `sdo` then presents D0 to D6, least significant bit first, and advances on each falling edge, so Dk is valid at rising edge 9+k. A control register reads back its stored bits, with D5 always 0.
- R5: A read of the status address 8*c+7 returns the channel's `loss_in` bit on D0 and 0 on D1 to D6.
- R6: A write to an address that maps to no register changes no output. A read of such an address returns 0 on all seven bits.
- R7: A frame with A5 = 1 is ignored. No register is written, and `sdo_oe` stays 0 for the whole frame.
- R8: When chip select is released mid-frame, the frame is aborted: `sdo_oe` returns to 0, a write that is not complete commits nothing, and the next frame decodes from its first bit.
- R9: A write to a status address changes no control output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| loss_in | input | NCH | Per-channel loss-of-lock flag, reported in the status register |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the `sdo` pad driver |
| fifo_sel | output | NCH | Per-channel FIFO depth select (control D0) |
| clk_edge_sel | output | NCH | Per-channel clock edge select (control D1) |
| bw_sel | output | NCH | Per-channel bandwidth select (control D2) |
| ja_bypass | output | NCH | Per-channel attenuator bypass (control D3) |
| e3_sel | output | NCH | Per-channel E3/DS3 select (control D4) |
| sts1_sel | output | NCH | Per-channel STS-1 select (control D6) |

## Verification
The hardest case to reach is a frame that ends early. The release of chip select has to land after a chosen number of serial edges, partway through a header or a write word, and the register state must then be shown to be untouched. The bench's frame task takes a count of rising edges after which it releases chip select. The bench then checks the control outputs and the data of a full read that follows at once. Frames with A5 set, writes to status and unmapped addresses, and a sweep over all 32 addresses cover the decode corners.

// File: rtl/sctl_pkg.sv
package sctl_pkg;

  localparam int ADDR_W   = 5;
  localparam int RD_W     = 7;
  localparam int WR_W     = 8;
  localparam int HDR_BITS = 8;
  localparam int FIXED0_BIT = 5;

  typedef struct packed {
    logic       hit;
    logic       status;
    logic [1:0] ch;
  } sctl_dec_t;

  // Channel c: control at 8*c+6, status at 8*c+7
  function automatic sctl_dec_t sctl_decode(input logic [ADDR_W-1:0] a, input int nch);
    sctl_dec_t d;
    d.status = a[0];
    d.ch     = a[4:3];
    d.hit    = (a[2:1] == 2'b11) && (int'(a[4:3]) < nch);
    return d;
  endfunction

endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST;
      q    <= RST;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/sctl_frame.sv
module sctl_frame
  import sctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_s,
  input  logic              sclk_s,
  input  logic              sdi_s,
  input  logic [RD_W-1:0]   rd_word,
  output logic [ADDR_W-1:0] addr,
  output logic [RD_W-1:0]   wr_data,
  output logic              wr_stb,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam int LAST  = HDR_BITS + WR_W;
  localparam int CNT_W = $clog2(LAST + 1);

  logic              sclk_d, rise, fall;
  logic [CNT_W-1:0]  cnt;
  logic              rw_q, a5_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WR_W-1:0]   wsh;
  logic [RD_W-1:0]   rsh;

  assign rise = sclk_s & ~sclk_d & ~cs_n_s;
  assign fall = ~sclk_s & sclk_d & ~cs_n_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      cnt    <= '0;
      rw_q   <= 1'b0;
      a5_q   <= 1'b0;
      addr_q <= '0;
      wsh    <= '0;
      rsh    <= '0;
      sdo    <= 1'b0;
      sdo_oe <= 1'b0;
      wr_stb <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      wr_stb <= 1'b0;
      if (cs_n_s) begin
        cnt    <= '0;
        sdo_oe <= 1'b0;
        sdo    <= 1'b0;
      end else begin
        if (rise) begin
          if (cnt != CNT_W'(LAST)) cnt <= cnt + 1'b1;
          if (cnt == '0) begin
            rw_q <= sdi_s;
          end else if (cnt <= CNT_W'(ADDR_W)) begin
            addr_q <= {sdi_s, addr_q[ADDR_W-1:1]};
          end else if (cnt == CNT_W'(ADDR_W + 1)) begin
            a5_q <= sdi_s;
          end else if (cnt >= CNT_W'(HDR_BITS) && cnt < CNT_W'(LAST)) begin
            wsh <= {sdi_s, wsh[WR_W-1:1]};
            if (cnt == CNT_W'(LAST - 1) && !rw_q && !a5_q) wr_stb <= 1'b1;
          end
        end
        if (fall && cnt >= CNT_W'(HDR_BITS) && rw_q && !a5_q) begin
          if (!sdo_oe) begin
            sdo_oe <= 1'b1;
            sdo    <= rd_word[0];
            rsh    <= rd_word >> 1;
          end else begin
            sdo    <= rsh[0];
            rsh    <= rsh >> 1;
          end
        end
      end
    end
  end

  assign addr    = addr_q;
  assign wr_data = wsh[RD_W-1:0];

  assert_sdo_off_idle_R8: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |=> !sdo_oe);
  assert_oe_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(sdo_oe) |-> $past(fall));
  assert_stb_full_frame_R3: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> (cnt == CNT_W'(LAST)) && !rw_q);
  assert_a5_silent_R7: assert property (@(posedge clk) disable iff (rst)
    sdo_oe |-> !a5_q);
endmodule

// File: rtl/sctl_regbank.sv
module sctl_regbank
  import sctl_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_stb,
  input  logic [RD_W-1:0]   wr_data,
  input  logic [NCH-1:0]    loss_in,
  output logic [RD_W-1:0]   rd_word,
  output logic [NCH*RD_W-1:0] ctl_flat
);
  localparam logic [RD_W-1:0] WMASK = ~(RD_W'(1) << FIXED0_BIT);

  sctl_dec_t      dec;
  logic [NCH-1:0] loss_s;

  assign dec = sctl_decode(addr, NCH);

  sctl_sync #(.W(NCH), .RST('0)) u_loss_sync (
    .clk(clk), .rst(rst), .d(loss_in), .q(loss_s)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [RD_W-1:0] ctl_q;
    always_ff @(posedge clk) begin
      if (rst) ctl_q <= '0;
      else if (wr_stb && dec.hit && !dec.status && int'(dec.ch) == c)
        ctl_q <= wr_data & WMASK;
    end
    assign ctl_flat[c*RD_W +: RD_W] = ctl_q;
  end

  always_comb begin
    rd_word = '0;
    for (int c = 0; c < NCH; c++) begin
      if (dec.hit && int'(dec.ch) == c)
        rd_word = dec.status ? RD_W'(loss_s[c]) : ctl_flat[c*RD_W +: RD_W];
    end
  end

  assert_ctl_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !wr_stb |=> $stable(ctl_flat));
endmodule

// File: rtl/sctl_port.sv
module sctl_port
  import sctl_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cs_n,
  input  logic           sclk,
  input  logic           sdi,
  input  logic [NCH-1:0] loss_in,
  output logic           sdo,
  output logic           sdo_oe,
  output logic [NCH-1:0] fifo_sel,
  output logic [NCH-1:0] clk_edge_sel,
  output logic [NCH-1:0] bw_sel,
  output logic [NCH-1:0] ja_bypass,
  output logic [NCH-1:0] e3_sel,
  output logic [NCH-1:0] sts1_sel
);
  logic [2:0]          pins_s;
  logic [ADDR_W-1:0]   addr;
  logic [RD_W-1:0]     wr_data, rd_word;
  logic                wr_stb;
  logic [NCH*RD_W-1:0] ctl_flat;

  sctl_sync #(.W(3), .RST(3'b100)) u_pin_sync (
    .clk(clk), .rst(rst), .d({cs_n, sclk, sdi}), .q(pins_s)
  );

  sctl_frame u_frame (
    .clk(clk), .rst(rst),
    .cs_n_s(pins_s[2]), .sclk_s(pins_s[1]), .sdi_s(pins_s[0]),
    .rd_word(rd_word), .addr(addr), .wr_data(wr_data), .wr_stb(wr_stb),
    .sdo(sdo), .sdo_oe(sdo_oe)
  );

  sctl_regbank #(.NCH(NCH)) u_regs (
    .clk(clk), .rst(rst), .addr(addr), .wr_stb(wr_stb), .wr_data(wr_data),
    .loss_in(loss_in), .rd_word(rd_word), .ctl_flat(ctl_flat)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_out
    assign fifo_sel[c]     = ctl_flat[c*RD_W + 0];
    assign clk_edge_sel[c] = ctl_flat[c*RD_W + 1];
    assign bw_sel[c]       = ctl_flat[c*RD_W + 2];
    assign ja_bypass[c]    = ctl_flat[c*RD_W + 3];
    assign e3_sel[c]       = ctl_flat[c*RD_W + 4];
    assign sts1_sel[c]     = ctl_flat[c*RD_W + 6];
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> !sdo_oe && ctl_flat == '0);
endmodule

// File: tb/tb_sctl_port.sv
module tb_sctl_port;
  localparam int NCH = 3;

  logic clk = 1'b0, rst = 1'b1, cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [NCH-1:0] loss_in = '0;
  logic sdo, sdo_oe;
  logic [NCH-1:0] fifo_sel, clk_edge_sel, bw_sel, ja_bypass, e3_sel, sts1_sel;

  int checks = 0, errors = 0;
  logic [6:0] ctl_m [NCH];

  always #4 clk = ~clk;

  sctl_port #(.NCH(NCH)) dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .loss_in(loss_in),
    .sdo(sdo), .sdo_oe(sdo_oe), .fifo_sel(fifo_sel), .clk_edge_sel(clk_edge_sel),
    .bw_sel(bw_sel), .ja_bypass(ja_bypass), .e3_sel(e3_sel), .sts1_sel(sts1_sel)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] out_word(input int c);
    return {sts1_sel[c], 1'b0, e3_sel[c], ja_bypass[c], bw_sel[c], clk_edge_sel[c], fifo_sel[c]};
  endfunction

  task automatic chk_outs(input string tag);
    for (int c = 0; c < NCH; c++) chk(32'(out_word(c)), 32'(ctl_m[c]), tag);
  endtask

  function automatic bit is_ctl(input logic [4:0] a);
    return a[2:1] == 2'b11 && !a[0] && int'(a[4:3]) < NCH;
  endfunction

  function automatic logic [6:0] exp_read(input logic [4:0] a);
    if (a[2:1] != 2'b11 || int'(a[4:3]) >= NCH) return 7'h00;
    if (a[0]) return {6'b0, loss_in[a[4:3]]};
    return ctl_m[a[4:3]];
  endfunction

  // stop_after: number of rising edges before chip select is released (16 = full)
  task automatic frame(input bit rw, input logic [4:0] a, input bit a5, input bit a6,
                       input logic [7:0] wd, input int stop_after,
                       output logic [6:0] rd, output bit oe_ok);
    logic [15:0] bits;
    bits = {wd, a6, a5, a, rw};
    rd = '0;
    oe_ok = 1'b1;
    @(negedge clk) cs_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      if (i == stop_after) break;
      sdi = rw && i >= 8 ? 1'b0 : bits[i];
      repeat (8) @(negedge clk);
      if (sdo_oe !== (rw && !a5 && i >= 8)) oe_ok = 1'b0;
      if (rw && i >= 8 && i < 15) rd[i-8] = sdo;
      sclk = 1'b1;
      repeat (8) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (8) @(negedge clk);
    cs_n = 1'b1;
    sdi = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic do_write(input logic [4:0] a, input logic [7:0] wd, input bit a6);
    logic [6:0] rd;
    bit ok;
    frame(1'b0, a, 1'b0, a6, wd, 16, rd, ok);
    chk(32'(ok), 1, "R2 sdo_oe low during write");
    if (is_ctl(a)) ctl_m[a[4:3]] = wd[6:0] & 7'h5F;
  endtask

  task automatic do_read(input logic [4:0] a, input bit a6, input string tag);
    logic [6:0] rd;
    bit ok;
    frame(1'b1, a, 1'b0, a6, 8'h00, 16, rd, ok);
    chk(32'(ok), 1, "R4 sdo_oe timing in read");
    chk(32'(rd), 32'(exp_read(a)), tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [6:0] rd;
    bit ok;
    for (int c = 0; c < NCH; c++) ctl_m[c] = '0;
    repeat (10) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk_outs("R1 control outputs after reset");
    chk(32'(sdo_oe), 0, "R1 sdo_oe after reset");

    // Write sweep over all addresses: R3 mapped, R6 unmapped, R9 status
    for (int a = 0; a < 32; a++) begin
      do_write(5'(a), 8'(a * 29 + 8'h5B), a[0]);
      if (is_ctl(5'(a))) chk_outs("R3 write sweep");
      else if (a[0] && a[2:1] == 2'b11) chk_outs("R9 status write ignored");
      else chk_outs("R6 unmapped write ignored");
    end

    // Read sweep: R4 control, R5 status, R6 unmapped; A6 toggled (R2)
    loss_in = 3'b101;
    repeat (4) @(negedge clk);
    for (int a = 0; a < 32; a++)
      do_read(5'(a), ~a[1], is_ctl(5'(a)) ? "R4 control readback" :
              (a[0] && a[2:1] == 2'b11 && a[4:3] < NCH) ? "R5 status readback" : "R6 unmapped read");
    loss_in = 3'b010;
    repeat (4) @(negedge clk);
    for (int c = 0; c < NCH; c++) do_read(5'(c * 8 + 7), 1'b1, "R5 status follows loss_in");

    // Walking one per channel and bit: R3 bit map, R4 readback with D5 forced 0
    for (int c = 0; c < NCH; c++)
      for (int b = 0; b < 8; b++) begin
        do_write(5'(c * 8 + 6), 8'(1 << b), b[0]);
        chk_outs("R3 walking bit outputs");
        do_read(5'(c * 8 + 6), 1'b0, "R4 walking bit readback");
      end

    // R7 A5 set: no write, no output drive
    do_write(5'h06, 8'h15, 1'b0);
    frame(1'b0, 5'h06, 1'b1, 1'b0, 8'h6A, 16, rd, ok);
    chk_outs("R7 write with A5 set ignored");
    frame(1'b1, 5'h06, 1'b1, 1'b0, 8'h00, 16, rd, ok);
    chk(32'(ok), 1, "R7 sdo_oe stays low with A5 set");

    // R8 aborts
    do_write(5'h0E, 8'h42, 1'b0);
    frame(1'b0, 5'h0E, 1'b0, 1'b0, 8'h3D, 15, rd, ok);
    chk_outs("R8 write aborted after 15 edges");
    frame(1'b0, 5'h16, 1'b0, 1'b0, 8'h7F, 4, rd, ok);
    chk_outs("R8 write aborted in header");
    frame(1'b1, 5'h0E, 1'b0, 1'b0, 8'h00, 11, rd, ok);
    chk(32'(ok), 1, "R8 partial read oe timing");
    chk(32'(sdo_oe), 0, "R8 sdo_oe released after abort");
    do_read(5'h0E, 1'b0, "R8 full read after abort");
    do_read(5'h06, 1'b1, "R8 second read after abort");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule